// File: doc/BRIEF.md
# SDRAM Command Timing Enforcer

This block is a command gate placed between the command issuer of a memory controller and a two-bank SDRAM. The issuer presents one command per cycle: a row open, column read, column write, row close or burst stop, together with a bank number. The gate holds back any command that would break a minimum spacing rule, and drops commands that make no sense for the bank's current state.

Row timings are parameters given in nanoseconds. At elaboration they are turned into clock counts from a clock-period parameter in picoseconds. Write recovery, burst-stop and column spacing are parameters counted in whole clocks. The spacing from a read to a row close is derived from the CAS latency and the burst length. The gate keeps track of whether each bank has an open row. It raises a per-bank flag when a row has been open longer than the maximum row-active time.

The handshake is combinational on the presented command. `cmd_ready` says that the command leaves the gate this cycle. `cmd_issue` marks that it went to the memory. `cmd_error` marks that it was dropped.

Top module: `sdram_cmd_gate`

## Requirements
- R1: Every nanosecond limit becomes ceil(ns * 1000 / CLK_PS) clocks, with a minimum of 1. A gap of N clocks means that a command gated by an event in cycle t may issue in cycle t+N at the earliest. At the default 7000 ps this gives 2 clocks for the bank-to-bank open spacing, 3 for open to column, 3 for close to open, 6 for open to close, 9 for open to open in the same bank and 14286 for the maximum open time.
- R2: Command codes on `cmd_code` are 1 = open row, 2 = read, 3 = write, 4 = close row and 5 = burst stop. `cmd_ready` is high exactly when `cmd_valid` is high and the command is either issuable or rejected. `cmd_issue` equals `cmd_ready` and not `cmd_error`. With `cmd_valid` low, all three outputs are low.
- R3: An open-row command to a bank cannot issue within the bank-to-bank gap (14 ns) after an open-row command to a different bank.
- R4: A read or write to a bank cannot issue within the open-to-column gap (20 ns) after that bank's open-row command.
- R5: An open-row command to a bank cannot issue within the close-to-open gap (20 ns) after that bank's close. It also cannot issue within the open-to-open gap (63 ns) after that bank's previous open.
- R6: A close to a bank cannot issue within the minimum open time (42 ns) after that bank's open-row command.
- R7: A close to a bank cannot issue within max(1, CAS_LAT + BURST_LEN - 2) clocks after a read to that bank. CAS_LAT must be 2 or 3.
- R8: A close to the bank of the most recent write is held from that write until the last-write-data strobe. It is also held in the strobe cycle and for a gap of 2 clocks counted from the strobe.
- R9: A read, write or burst stop cannot issue in a cycle where `wdata_last` is high. It may issue one clock later, since the column and burst-stop gaps after the strobe are 1 clock and the column-to-column gap is 1 clock.
- R10: The following commands are rejected with a one-cycle `cmd_error`, with `cmd_ready` high and no issue: a read, write or close to a bank with no open row, an open-row command to a bank with a row already open, and any code other than 1 to 5. A rejected command changes no bank state and restarts no timer.
- R11: `row_overtime[b]` goes high on the cycle after bank b's row has been open for more than the maximum open time in clocks. A row opened at cycle t flags from cycle t + limit + 1. The flag stays high until the close issues and is low from the next cycle.
- R12: Synchronous active-high `rst` marks both banks idle, clears every flag and leaves every gap expired, so an open-row command presented in the first cycle after reset issues at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented |
| cmd_code | input | 3 | Command code (see R2) |
| cmd_bank | input | BANK_W | Target bank |
| wdata_last | input | 1 | Last write data beat of the current write burst |
| cmd_ready | output | 1 | Presented command leaves the gate this cycle |
| cmd_issue | output | 1 | Presented command goes to the memory this cycle |
| cmd_error | output | 1 | Presented command is dropped as illegal |
| row_overtime | output | BANK_CNT | Per-bank row open past its maximum time |

## Verification
The assertions check on every cycle that the handshake outputs agree with one another. They also check that no column or burst-stop command slips through in a strobe cycle and that two open-row commands never issue back to back to different banks. Further per-cycle checks cover that a column command never issues right after its own bank was opened, that issued column and close commands always find an open row, and that a close clears the overtime flag. The exact number of stall cycles for each gap, and the overlap of read-to-close with the minimum open time, can only be shown by the bench's scenarios. The same holds for the write-pending hold, the absence of side effects from rejected commands and the overtime threshold at its exact cycle.

// File: rtl/sdram_gate_pkg.sv
package sdram_gate_pkg;

   typedef enum logic [2:0] {
      C_NONE = 3'd0,
      C_ACT  = 3'd1,
      C_RD   = 3'd2,
      C_WR   = 3'd3,
      C_PRE  = 3'd4,
      C_BST  = 3'd5
   } cmd_t;

   // Nanoseconds to whole clocks, rounded up, never below one clock.
   function automatic int ns_to_clk(input int ns, input int clk_ps);
      int c;
      c = (ns * 1000 + clk_ps - 1) / clk_ps;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int at_least_one(input int v);
      return (v < 1) ? 1 : v;
   endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
// Holds busy for GAP-1 cycles after the cycle in which fire is high.
module sdram_gap_timer #(
   parameter int GAP = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic fire,
   output logic busy
);
   if (GAP <= 1) begin : g_none
      logic unused_in;
      assign unused_in = &{1'b0, clk, rst, fire};
      assign busy = 1'b0;
   end else begin : g_cnt
      localparam int W = $clog2(GAP);
      logic [W-1:0] cnt;
      always_ff @(posedge clk) begin
         if (rst)              cnt <= '0;
         else if (fire)        cnt <= W'(GAP - 1);
         else if (cnt != '0)   cnt <= cnt - W'(1);
      end
      assign busy = (cnt != '0);
   end
endmodule

// File: rtl/sdram_bank_track.sv
// Per-bank state: open row flag, write-pending flag, spacing timers, row age.
module sdram_bank_track #(
   parameter int RCD_C = 1,
   parameter int RAS_C = 1,
   parameter int RP_C  = 1,
   parameter int RC_C  = 1,
   parameter int RRD_C = 1,
   parameter int RTP_C = 1,
   parameter int RDL_C = 2,
   parameter int AGE_MAX = 1,
   localparam int AGE_W = $clog2(AGE_MAX + 2)
) (
   input  logic clk,
   input  logic rst,
   input  logic act_go,
   input  logic rd_go,
   input  logic wr_go,
   input  logic pre_go,
   input  logic wstrobe,
   output logic is_open,
   output logic act_ok,
   output logic col_ok,
   output logic pre_ok,
   output logic rrd_busy,
   output logic overtime
);
   logic rcd_busy, ras_busy, rp_busy, rc_busy, rtp_busy, rdl_busy;
   logic wr_pend;
   logic [AGE_W-1:0] age;

   sdram_gap_timer #(.GAP(RCD_C)) u_rcd (.clk, .rst, .fire(act_go),  .busy(rcd_busy));
   sdram_gap_timer #(.GAP(RAS_C)) u_ras (.clk, .rst, .fire(act_go),  .busy(ras_busy));
   sdram_gap_timer #(.GAP(RC_C))  u_rc  (.clk, .rst, .fire(act_go),  .busy(rc_busy));
   sdram_gap_timer #(.GAP(RRD_C)) u_rrd (.clk, .rst, .fire(act_go),  .busy(rrd_busy));
   sdram_gap_timer #(.GAP(RP_C))  u_rp  (.clk, .rst, .fire(pre_go),  .busy(rp_busy));
   sdram_gap_timer #(.GAP(RTP_C)) u_rtp (.clk, .rst, .fire(rd_go),   .busy(rtp_busy));
   sdram_gap_timer #(.GAP(RDL_C)) u_rdl (.clk, .rst, .fire(wstrobe), .busy(rdl_busy));

   always_ff @(posedge clk) begin
      if (rst) begin
         is_open <= 1'b0;
         wr_pend <= 1'b0;
         age     <= '0;
      end else begin
         if (act_go)      is_open <= 1'b1;
         else if (pre_go) is_open <= 1'b0;
         if (wstrobe)     wr_pend <= 1'b0;
         if (wr_go)       wr_pend <= 1'b1;
         if (act_go)
            age <= AGE_W'(1);
         else if (pre_go)
            age <= '0;
         else if (is_open && age <= AGE_W'(AGE_MAX))
            age <= age + AGE_W'(1);
      end
   end

   assign act_ok   = !rp_busy && !rc_busy;
   assign col_ok   = !rcd_busy;
   assign pre_ok   = !ras_busy && !rtp_busy && !rdl_busy && !wr_pend && !wstrobe;
   assign overtime = is_open && (age > AGE_W'(AGE_MAX));
endmodule

// File: rtl/sdram_cmd_gate.sv
module sdram_cmd_gate
   import sdram_gate_pkg::*;
#(
   parameter int CLK_PS       = 7000,
   parameter int CAS_LAT      = 3,
   parameter int BURST_LEN    = 4,
   parameter int BANK_CNT     = 2,
   parameter int T_RRD_NS     = 14,
   parameter int T_RCD_NS     = 20,
   parameter int T_RP_NS      = 20,
   parameter int T_RAS_NS     = 42,
   parameter int T_RC_NS      = 63,
   parameter int T_RAS_MAX_NS = 100000,
   parameter int CDL_CLK      = 1,
   parameter int RDL_CLK      = 2,
   parameter int BDL_CLK      = 1,
   localparam int BANK_W = (BANK_CNT > 1) ? $clog2(BANK_CNT) : 1
) (
   input  logic                cmd_valid,
   input  logic                clk,
   input  logic                rst,
   input  logic [2:0]          cmd_code,
   input  logic [BANK_W-1:0]   cmd_bank,
   input  logic                wdata_last,
   output logic                cmd_ready,
   output logic                cmd_issue,
   output logic                cmd_error,
   output logic [BANK_CNT-1:0] row_overtime
);
   localparam int RRD_C   = ns_to_clk(T_RRD_NS, CLK_PS);
   localparam int RCD_C   = ns_to_clk(T_RCD_NS, CLK_PS);
   localparam int RP_C    = ns_to_clk(T_RP_NS, CLK_PS);
   localparam int RAS_C   = ns_to_clk(T_RAS_NS, CLK_PS);
   localparam int RC_C    = ns_to_clk(T_RC_NS, CLK_PS);
   localparam int AGE_MAX = ns_to_clk(T_RAS_MAX_NS, CLK_PS);
   localparam int RTP_C   = at_least_one(CAS_LAT + BURST_LEN - 2);

   initial begin : elab_chk
      assert (CAS_LAT == 2 || CAS_LAT == 3) else $error("CAS_LAT must be 2 or 3");
      assert (BURST_LEN >= 1)               else $error("BURST_LEN must be positive");
      assert (CLK_PS > 0)                   else $error("CLK_PS must be positive");
      assert (BANK_CNT >= 2)                else $error("BANK_CNT must be at least 2");
   end

   cmd_t code;
   logic [BANK_CNT-1:0] sel, bank_open, act_ok, col_ok, pre_ok, rrd_busy, wstb;
   logic [BANK_CNT-1:0] act_go, rd_go, wr_go, pre_go;
   logic [BANK_W-1:0]   wr_bank;
   logic cdl_busy, bdl_busy, state_bad, timing_ok;

   assign code = cmd_t'(cmd_code);

   always_comb begin
      sel = '0;
      sel[cmd_bank] = 1'b1;
      for (int i = 0; i < BANK_CNT; i++)
         wstb[i] = wdata_last && (wr_bank == BANK_W'(i));
   end

   always_comb begin
      case (code)
         C_ACT:               state_bad = bank_open[cmd_bank];
         C_RD, C_WR, C_PRE:   state_bad = !bank_open[cmd_bank];
         C_BST:               state_bad = 1'b0;
         default:             state_bad = 1'b1;
      endcase
      case (code)
         C_ACT:      timing_ok = act_ok[cmd_bank] && ((rrd_busy & ~sel) == '0);
         C_RD, C_WR: timing_ok = col_ok[cmd_bank] && !wdata_last && !cdl_busy;
         C_PRE:      timing_ok = pre_ok[cmd_bank];
         C_BST:      timing_ok = !wdata_last && !bdl_busy;
         default:    timing_ok = 1'b0;
      endcase
   end

   assign cmd_error = cmd_valid && state_bad;
   assign cmd_issue = cmd_valid && !state_bad && timing_ok;
   assign cmd_ready = cmd_error || cmd_issue;

   assign act_go = sel & {BANK_CNT{cmd_issue && code == C_ACT}};
   assign rd_go  = sel & {BANK_CNT{cmd_issue && code == C_RD}};
   assign wr_go  = sel & {BANK_CNT{cmd_issue && code == C_WR}};
   assign pre_go = sel & {BANK_CNT{cmd_issue && code == C_PRE}};

   always_ff @(posedge clk) begin
      if (rst)                              wr_bank <= '0;
      else if (cmd_issue && code == C_WR)   wr_bank <= cmd_bank;
   end

   sdram_gap_timer #(.GAP(CDL_CLK)) u_cdl (.clk, .rst, .fire(wdata_last), .busy(cdl_busy));
   sdram_gap_timer #(.GAP(BDL_CLK)) u_bdl (.clk, .rst, .fire(wdata_last), .busy(bdl_busy));

   for (genvar b = 0; b < BANK_CNT; b++) begin : g_bank
      sdram_bank_track #(
         .RCD_C(RCD_C), .RAS_C(RAS_C), .RP_C(RP_C), .RC_C(RC_C),
         .RRD_C(RRD_C), .RTP_C(RTP_C), .RDL_C(RDL_CLK), .AGE_MAX(AGE_MAX)
      ) u_trk (
         .clk, .rst,
         .act_go(act_go[b]), .rd_go(rd_go[b]), .wr_go(wr_go[b]), .pre_go(pre_go[b]),
         .wstrobe(wstb[b]),
         .is_open(bank_open[b]), .act_ok(act_ok[b]), .col_ok(col_ok[b]),
         .pre_ok(pre_ok[b]), .rrd_busy(rrd_busy[b]), .overtime(row_overtime[b])
      );
   end
endmodule

// File: rtl/sdram_cmd_gate_chk.sv
module sdram_cmd_gate_chk
   import sdram_gate_pkg::*;
#(
   parameter int BANK_CNT = 2,
   parameter int BANK_W   = 1,
   parameter int RRD_C    = 1,
   parameter int RCD_C    = 1
) (
   input logic                clk,
   input logic                rst,
   input logic                cmd_valid,
   input logic [2:0]          cmd_code,
   input logic [BANK_W-1:0]   cmd_bank,
   input logic                wdata_last,
   input logic                cmd_ready,
   input logic                cmd_issue,
   input logic                cmd_error,
   input logic [BANK_CNT-1:0] row_overtime,
   input logic [BANK_CNT-1:0] bank_open
);
   logic is_act, is_col, is_pre, is_bst;
   assign is_act = cmd_code == C_ACT;
   assign is_col = (cmd_code == C_RD) || (cmd_code == C_WR);
   assign is_pre = cmd_code == C_PRE;
   assign is_bst = cmd_code == C_BST;

   p_handshake_r2: assert property (@(posedge clk) disable iff (rst)
      cmd_issue |-> (cmd_valid && cmd_ready && !cmd_error));

   p_error_ready_r2: assert property (@(posedge clk) disable iff (rst)
      cmd_error |-> (cmd_ready && !cmd_issue));

   if (RRD_C >= 2) begin : g_rrd
      p_act_spacing_r3: assert property (@(posedge clk) disable iff (rst)
         (cmd_issue && is_act && $past(cmd_issue && is_act)) |-> (cmd_bank == $past(cmd_bank)));
   end

   if (RCD_C >= 2) begin : g_rcd
      p_col_after_open_r4: assert property (@(posedge clk) disable iff (rst)
         (cmd_issue && is_col && $past(cmd_issue && is_act)) |-> (cmd_bank != $past(cmd_bank)));
   end

   p_strobe_blocks_col_r9: assert property (@(posedge clk) disable iff (rst)
      wdata_last |-> !(cmd_issue && (is_col || is_bst)));

   p_needs_open_r10: assert property (@(posedge clk) disable iff (rst)
      (cmd_issue && (is_col || is_pre)) |-> bank_open[cmd_bank]);

   p_open_after_act_r10: assert property (@(posedge clk) disable iff (rst)
      (cmd_issue && is_act) |=> bank_open[$past(cmd_bank)]);

   p_flag_clears_r11: assert property (@(posedge clk) disable iff (rst)
      (cmd_issue && is_pre) |=> !row_overtime[$past(cmd_bank)]);

   p_reset_idle_r12: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (bank_open == '0 && row_overtime == '0));
endmodule

bind sdram_cmd_gate sdram_cmd_gate_chk #(
   .BANK_CNT(BANK_CNT), .BANK_W(BANK_W), .RRD_C(RRD_C), .RCD_C(RCD_C)
) u_chk (
   .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
   .cmd_bank(cmd_bank), .wdata_last(wdata_last), .cmd_ready(cmd_ready),
   .cmd_issue(cmd_issue), .cmd_error(cmd_error), .row_overtime(row_overtime),
   .bank_open(bank_open)
);

// File: tb/tb_sdram_cmd_gate.sv
module tb_sdram_cmd_gate;
   localparam int CLK_PS = 7000;
   localparam int CL = 3;
   localparam int BL = 4;

   function automatic int cdiv(input int ns);
      int c;
      c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
      return (c < 1) ? 1 : c;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int B_RRD = (14 * 1000 + CLK_PS - 1) / CLK_PS;
   localparam int B_RCD = (20 * 1000 + CLK_PS - 1) / CLK_PS;
   localparam int B_RP  = (20 * 1000 + CLK_PS - 1) / CLK_PS;
   localparam int B_RAS = (42 * 1000 + CLK_PS - 1) / CLK_PS;
   localparam int B_RC  = (63 * 1000 + CLK_PS - 1) / CLK_PS;
   localparam int B_AGE = (100000 * 1000 + CLK_PS - 1) / CLK_PS;
   localparam int B_RTP = (CL + BL - 2 < 1) ? 1 : CL + BL - 2;
   localparam int B_CDL = 1;
   localparam int B_RDL = 2;
   localparam int B_BDL = 1;

   logic clk = 1'b0, rst = 1'b1, cmd_valid = 1'b0, wdata_last = 1'b0;
   logic [2:0] cmd_code = 3'd0;
   logic [0:0] cmd_bank = 1'b0;
   logic cmd_ready, cmd_issue, cmd_error;
   logic [1:0] row_overtime;

   sdram_cmd_gate #(.CLK_PS(CLK_PS), .CAS_LAT(CL), .BURST_LEN(BL)) dut (
      .cmd_valid, .clk, .rst, .cmd_code, .cmd_bank, .wdata_last,
      .cmd_ready, .cmd_issue, .cmd_error, .row_overtime);

   always #10 clk = ~clk;

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit done = 1'b0;
   // reference model, stamps in cycles
   int m_act[2], m_pre[2], m_rd[2], m_wst[2], m_stb;
   bit m_open[2], m_pend[2];
   int m_wbank;

   task automatic cmp(input string what, input longint act, input longint exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", what, act, exp);
      end
   endtask

   function automatic bit m_bad(input logic [2:0] c, input int b);
      case (c)
         3'd1:             return m_open[b];
         3'd2, 3'd3, 3'd4: return !m_open[b];
         3'd5:             return 1'b0;
         default:          return 1'b1;
      endcase
   endfunction

   function automatic bit m_ok(input logic [2:0] c, input int b);
      case (c)
         3'd1: return (cyc - m_pre[b] >= B_RP) && (cyc - m_act[b] >= B_RC) &&
                      (cyc - m_act[1-b] >= B_RRD);
         3'd2, 3'd3: return (cyc - m_act[b] >= B_RCD) && (cyc - m_stb >= B_CDL);
         3'd4: return (cyc - m_act[b] >= B_RAS) && (cyc - m_rd[b] >= B_RTP) &&
                      !m_pend[b] && (cyc - m_wst[b] >= B_RDL);
         3'd5: return (cyc - m_stb >= B_BDL);
         default: return 1'b0;
      endcase
   endfunction

   function automatic void m_reset();
      for (int b = 0; b < 2; b++) begin
         m_act[b] = -1000000; m_pre[b] = -1000000; m_rd[b] = -1000000;
         m_wst[b] = -1000000; m_open[b] = 1'b0; m_pend[b] = 1'b0;
      end
      m_stb = -1000000; m_wbank = 0;
   endfunction

   task automatic do_reset();
      rst = 1'b1; cmd_valid = 1'b0; wdata_last = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_reset();
      cyc = 0;
   endtask

   // One cycle: drive at negedge, compare combinational and registered outputs, advance.
   task automatic step(input bit v, input logic [2:0] c, input int b, input bit stb,
                       input string tag, output bit got, output bit err);
      bit eb, eo;
      cmd_valid = v; cmd_code = c; cmd_bank = 1'(b); wdata_last = stb;
      #2;
      if (stb) begin
         m_stb = cyc; m_wst[m_wbank] = cyc; m_pend[m_wbank] = 1'b0;
      end
      eb = v && m_bad(c, b);
      eo = v && !eb && m_ok(c, b);
      cmp({tag, " ready"}, cmd_ready, eb || eo);
      cmp({tag, " issue"}, cmd_issue, eo);
      cmp({tag, " error"}, cmd_error, eb);
      for (int k = 0; k < 2; k++)
         cmp({tag, " overtime"}, row_overtime[k], m_open[k] && (cyc - m_act[k] > B_AGE));
      got = cmd_issue; err = cmd_error;
      if (eo) begin
         case (c)
            3'd1: begin m_open[b] = 1'b1; m_act[b] = cyc; end
            3'd2: m_rd[b] = cyc;
            3'd3: begin m_wbank = b; m_pend[b] = 1'b1; end
            3'd4: begin m_open[b] = 1'b0; m_pre[b] = cyc; end
            default: ;
         endcase
      end
      @(posedge clk);
      cyc++;
      @(negedge clk);
      cmd_valid = 1'b0; wdata_last = 1'b0;
   endtask

   task automatic hold(input logic [2:0] c, input int b, input string tag, output int at);
      bit got, err;
      at = -1;
      for (int k = 0; k < 60; k++) begin
         int c0;
         c0 = cyc;
         step(1'b1, c, b, 1'b0, tag, got, err);
         if (got || err) begin
            at = c0;
            break;
         end
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      int t0, t1, t2, t3, t4, t5, pres, s;
      bit got, err;
      void'($urandom(32'd20240611));
      @(negedge clk);
      do_reset();

      // reset state
      cmp("R12 idle ready", cmd_ready, 0);
      cmp("R12 overtime clear", row_overtime, 0);
      step(1'b0, 3'd0, 0, 1'b0, "R2 idle", got, err);

      // row timing sequence
      do_reset();
      hold(3'd1, 0, "R12 first open", t0);
      cmp("R12 open right after reset", t0, 0);
      pres = cyc; hold(3'd1, 1, "R3", t1);
      cmp("R1 R3 bank-to-bank open gap", t1, mx(pres, t0 + B_RRD));
      pres = cyc; hold(3'd2, 1, "R4", t2);
      cmp("R1 R4 open-to-read gap", t2, mx(pres, t1 + B_RCD));
      pres = cyc; hold(3'd4, 1, "R7", t3);
      cmp("R7 read-to-close gap", t3, mx(pres, mx(t1 + B_RAS, t2 + B_RTP)));
      pres = cyc; hold(3'd4, 0, "R6", t4);
      cmp("R6 close bank0", t4, mx(pres, t0 + B_RAS));
      pres = cyc; hold(3'd1, 0, "R5", t5);
      cmp("R5 close-to-open gap", t5, mx(pres, mx(t4 + B_RP, t0 + B_RC)));
      pres = cyc; hold(3'd4, 0, "R6", t4);
      cmp("R6 min open time", t4, mx(pres, t5 + B_RAS));
      pres = cyc; hold(3'd1, 0, "R5", t0);
      cmp("R5 open-to-open gap", t0, mx(pres, mx(t4 + B_RP, t5 + B_RC)));

      // write recovery
      do_reset();
      hold(3'd1, 0, "R8", t0);
      hold(3'd3, 0, "R8", t1);
      for (int k = 0; k < 3; k++) begin
         step(1'b1, 3'd4, 0, 1'b0, "R8 pending", got, err);
         cmp("R8 close held while write pending", got, 0);
      end
      s = cyc;
      step(1'b1, 3'd4, 0, 1'b1, "R8 strobe", got, err);
      cmp("R8 close held in strobe cycle", got, 0);
      step(1'b1, 3'd4, 0, 1'b0, "R8 after", got, err);
      cmp("R8 close one clock after strobe", got, (s + 1 >= s + B_RDL) ? 1 : 0);
      pres = cyc;
      step(1'b1, 3'd4, 0, 1'b0, "R8 after", got, err);
      cmp("R8 close two clocks after strobe", got,
          ((pres - s >= B_RDL) && (pres - t0 >= B_RAS)) ? 1 : 0);

      // strobe vs column and burst stop
      hold(3'd1, 1, "R9", t2);
      hold(3'd3, 1, "R9", t3);
      step(1'b1, 3'd5, 0, 1'b1, "R9 bst", got, err);
      cmp("R9 burst stop held in strobe cycle", got, 0);
      step(1'b1, 3'd5, 0, 1'b0, "R9 bst", got, err);
      cmp("R9 burst stop next clock", got, (B_BDL <= 1) ? 1 : 0);
      step(1'b1, 3'd2, 1, 1'b1, "R9 rd", got, err);
      cmp("R9 read held in strobe cycle", got, 0);
      step(1'b1, 3'd2, 1, 1'b0, "R9 rd", got, err);
      cmp("R9 read next clock", got, (B_CDL <= 1) ? 1 : 0);
      step(1'b1, 3'd2, 1, 1'b0, "R9 rd", got, err);
      cmp("R9 back-to-back read", got, 1);

      // rejections
      do_reset();
      step(1'b1, 3'd2, 0, 1'b0, "R10", got, err);
      cmp("R10 read to idle bank rejected", err, 1);
      step(1'b1, 3'd4, 1, 1'b0, "R10", got, err);
      cmp("R10 close to idle bank rejected", err, 1);
      step(1'b1, 3'd0, 0, 1'b0, "R10", got, err);
      cmp("R10 code 0 rejected", err, 1);
      step(1'b1, 3'd7, 1, 1'b0, "R10", got, err);
      cmp("R10 code 7 rejected", err, 1);
      hold(3'd1, 0, "R10", t0);
      step(1'b1, 3'd3, 1, 1'b0, "R10", got, err);
      cmp("R10 write to idle bank rejected", err, 1);
      step(1'b1, 3'd1, 0, 1'b0, "R10", got, err);
      cmp("R10 open to open bank rejected", err, 1);
      pres = cyc; hold(3'd4, 0, "R10", t1);
      cmp("R10 rejected open did not restart timer", t1, mx(pres, t0 + B_RAS));

      // row overtime
      do_reset();
      hold(3'd1, 1, "R11", t0);
      while (cyc < t0 + B_AGE) step(1'b0, 3'd0, 0, 1'b0, "R11 idle", got, err);
      cmp("R11 flag low at limit", row_overtime[1], 0);
      step(1'b0, 3'd0, 0, 1'b0, "R11 idle", got, err);
      cmp("R11 flag high past limit", row_overtime[1], 1);
      cmp("R11 other bank flag low", row_overtime[0], 0);
      hold(3'd4, 1, "R11 close", t1);
      cmp("R11 flag cleared by close", row_overtime[1], 0);

      // constrained random
      do_reset();
      for (int n = 0; n < 4000; n++) begin
         logic [2:0] rc;
         int pick;
         pick = int'($urandom % 12);
         rc = (pick < 3) ? 3'd1 : (pick < 5) ? 3'd2 : (pick < 7) ? 3'd3 :
              (pick < 9) ? 3'd4 : (pick < 10) ? 3'd5 : (pick < 11) ? 3'd0 : 3'd6;
         step(($urandom % 10) < 7, rc, int'($urandom % 2), ($urandom % 8) == 0,
              "R2 R3 R4 R5 R6 R7 R8 R9 R10 random", got, err);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule